// File: doc/BRIEF.md
# Sobel Edge-Magnitude Engine

This block turns a grayscale frame held in an external RAM into an edge-magnitude frame in a second external RAM. A controller pulses `start`. The engine first writes zero to every pixel on the frame perimeter. It then walks every interior position in raster order. At each position it combines the eight neighbours with a horizontal and a vertical 3x3 gradient kernel and writes the sum of the two absolute gradients, clipped to 8 bits. A one-cycle `done` pulse closes the frame.

The input RAM has two synchronous read ports with one cycle of read latency. Both kernels have a zero centre, so each output pixel needs eight reads. These are spread over four cycles, two reads per cycle. The four-cycle slots overlap from one pixel to the next, so a new interior pixel starts every four cycles. The frame width and height are parameters, 512x512 by default. Addresses are linear, `row*IMG_W + col`.

Top module: `sobel_edge_engine`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `rd_en` and `wr_en` are low until a start is accepted.
- R2: Every position with row 0, row IMG_H-1, column 0 or column IMG_W-1 is written with 0. All of these writes come before the first interior write of the frame.
- R3: Each interior output equals |Gx|+|Gy|. Gx uses the kernel rows (-1 0 1), (-2 0 2), (-1 0 1) and Gy uses (-1 -2 -1), (0 0 0), (1 2 1), where the first kernel row covers the pixel row above.
- R4: When |Gx|+|Gy| exceeds 255, the value written is 255.
- R5: `done` is high exactly 2*IMG_W + 2*(IMG_H-2) + 4*(IMG_W-2)*(IMG_H-2) + 3 cycles after the cycle in which an accepted `start` is high.
- R6: In one frame every output address is written exactly once, and no write happens while `busy` is low.
- R7: `done` lasts one cycle. `busy` is low in the cycle after `done`.
- R8: A `start` pulse while `busy` is high has no effect: the running frame keeps its timing and no second frame follows it.
- R9: Interior writes go in raster order: columns 1 to IMG_W-2 within a row, then the next row starting again at column 1.
- R10: `rd_en` is high for exactly 4*(IMG_W-2)*(IMG_H-2) cycles per frame, only while `busy` is high, and both read addresses stay inside the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a frame; ignored while busy |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after the last write |
| rd_en | output | 1 | Read strobe for both input RAM ports |
| rd_addr_a | output | ADDR_W | Input RAM address, port A |
| rd_addr_b | output | ADDR_W | Input RAM address, port B |
| rd_data_a | input | 8 | Port A data, one cycle after the address |
| rd_data_b | input | 8 | Port B data, one cycle after the address |
| wr_en | output | 1 | Output RAM write strobe |
| wr_addr | output | ADDR_W | Output RAM write address |
| wr_data | output | 8 | Output pixel value |

ADDR_W is $clog2(IMG_W*IMG_H).

## Verification
The frames are random noise, a vertical step, a horizontal step, and rising and falling linear ramps. The vertical step drives Gx alone into saturation. The horizontal step isolates Gy. The ramps give small exact gradients with both signs, so a wrong coefficient, a wrong sign or a missing absolute value shows up as a wrong value. Random noise mixes all neighbour positions, which exposes a swapped read address or a wrong phase. Each frame also carries a stray start pulse in mid-run, and the bench checks the exact frame length, the write order and the write count for every address.

// File: rtl/sobel_pkg.sv
package sobel_pkg;

    localparam int PIX_W  = 8;
    localparam int GRAD_W = 12;

    typedef logic [PIX_W-1:0]         pix_t;
    typedef logic signed [GRAD_W-1:0] grad_t;

    typedef struct packed {
        grad_t gx;
        grad_t gy;
    } grad_pair_t;

    // which neighbour pair is read in a slot of the four-cycle pixel window
    typedef enum logic [1:0] {
        PH_TOP = 2'd0,   // upper-left, upper-right
        PH_MID = 2'd1,   // left, right
        PH_BOT = 2'd2,   // lower-left, lower-right
        PH_COL = 2'd3    // above, below
    } phase_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BORDER,
        ST_INNER,
        ST_DRAIN
    } scan_st_e;

    function automatic grad_t widen(pix_t p);
        return grad_t'({{(GRAD_W-PIX_W){1'b0}}, p});
    endfunction

    // contribution of one neighbour pair to both gradients
    function automatic grad_pair_t phase_term(phase_e ph, pix_t a, pix_t b);
        grad_pair_t t;
        grad_t sa = widen(a);
        grad_t sb = widen(b);
        case (ph)
            PH_TOP: begin t.gx = sb - sa;         t.gy = -(sa + sb);       end
            PH_MID: begin t.gx = (sb - sa) <<< 1; t.gy = '0;               end
            PH_BOT: begin t.gx = sb - sa;         t.gy = sa + sb;          end
            default: begin t.gx = '0;             t.gy = (sb - sa) <<< 1;  end
        endcase
        return t;
    endfunction

    function automatic pix_t magnitude(grad_pair_t g);
        logic [GRAD_W-1:0] ax, ay;
        logic [GRAD_W:0]   s;
        ax = g.gx[GRAD_W-1] ? GRAD_W'(-g.gx) : GRAD_W'(g.gx);
        ay = g.gy[GRAD_W-1] ? GRAD_W'(-g.gy) : GRAD_W'(g.gy);
        s  = {1'b0, ax} + {1'b0, ay};
        return (s > (GRAD_W+1)'(255)) ? pix_t'(8'hFF) : s[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/sobel_scan.sv
module sobel_scan
    import sobel_pkg::*;
#(
    parameter int IMG_W  = 512,
    parameter int IMG_H  = 512,
    parameter int ADDR_W = $clog2(IMG_W*IMG_H)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              done_i,
    output logic              busy,
    output logic              bd_we,
    output logic [ADDR_W-1:0] bd_addr,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr_a,
    output logic [ADDR_W-1:0] rd_addr_b,
    output phase_e            rd_phase,
    output logic [ADDR_W-1:0] rd_ctr,
    output logic              rd_last
);
    localparam int COL_W = $clog2(IMG_W);
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [COL_W-1:0]  col_t;

    localparam addr_t A_ONE     = addr_t'(1);
    localparam addr_t A_WRAP    = addr_t'(3);
    localparam addr_t A_W       = addr_t'(IMG_W);
    localparam addr_t A_WM1     = addr_t'(IMG_W-1);
    localparam addr_t A_WP1     = addr_t'(IMG_W+1);
    localparam addr_t LAST_PIX  = addr_t'(IMG_W*IMG_H-1);
    localparam addr_t BOT_ROW   = addr_t'((IMG_H-1)*IMG_W);
    localparam addr_t FIRST_CTR = addr_t'(IMG_W+1);
    localparam addr_t LAST_CTR  = addr_t'((IMG_H-2)*IMG_W + IMG_W-2);
    localparam col_t  C_ONE     = col_t'(1);
    localparam col_t  C_LAST    = col_t'(IMG_W-1);
    localparam col_t  C_INNER   = col_t'(IMG_W-2);

    scan_st_e st;
    addr_t    pos;    // border address, or centre of the current pixel
    col_t     col;
    phase_e   ph;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            pos <= '0;
            col <= '0;
            ph  <= PH_TOP;
        end else begin
            case (st)
                ST_IDLE: if (start) begin
                    st  <= ST_BORDER;
                    pos <= '0;
                    col <= '0;
                end
                ST_BORDER: begin
                    if (pos == LAST_PIX) begin
                        st  <= ST_INNER;
                        pos <= FIRST_CTR;
                        col <= C_ONE;
                        ph  <= PH_TOP;
                    end else if (pos < A_W || pos >= BOT_ROW) begin
                        pos <= pos + A_ONE;
                        col <= (col == C_LAST) ? '0 : col + C_ONE;
                    end else if (col == '0) begin
                        pos <= pos + A_WM1;      // jump to the right edge
                        col <= C_LAST;
                    end else begin
                        pos <= pos + A_ONE;      // wrap to next row, left edge
                        col <= '0;
                    end
                end
                ST_INNER: begin
                    ph <= phase_e'(ph + 2'd1);
                    if (ph == PH_COL) begin
                        if (pos == LAST_CTR) begin
                            st <= ST_DRAIN;
                        end else if (col == C_INNER) begin
                            pos <= pos + A_WRAP;
                            col <= C_ONE;
                        end else begin
                            pos <= pos + A_ONE;
                            col <= col + C_ONE;
                        end
                    end
                end
                default: if (done_i) st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        case (ph)
            PH_TOP: begin rd_addr_a = pos - A_WP1; rd_addr_b = pos - A_WM1; end
            PH_MID: begin rd_addr_a = pos - A_ONE; rd_addr_b = pos + A_ONE; end
            PH_BOT: begin rd_addr_a = pos + A_WM1; rd_addr_b = pos + A_WP1; end
            default: begin rd_addr_a = pos - A_W;  rd_addr_b = pos + A_W;   end
        endcase
    end

    assign busy     = (st != ST_IDLE);
    assign bd_we    = (st == ST_BORDER);
    assign bd_addr  = pos;
    assign rd_en    = (st == ST_INNER);
    assign rd_phase = ph;
    assign rd_ctr   = pos;
    assign rd_last  = (pos == LAST_CTR);

endmodule

// File: rtl/sobel_accum.sv
module sobel_accum
    import sobel_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  phase_e            in_phase,
    input  logic [ADDR_W-1:0] in_ctr,
    input  logic              in_last,
    input  pix_t              rd_data_a,
    input  pix_t              rd_data_b,
    output logic              out_we,
    output logic [ADDR_W-1:0] out_addr,
    output pix_t              out_data,
    output logic              out_last
);
    // tag stage lines up with the one-cycle RAM latency
    logic              v_q;
    phase_e            ph_q;
    logic [ADDR_W-1:0] ctr_q;
    logic              last_q;
    grad_pair_t        acc, term, nxt;

    always_comb begin
        term   = phase_term(ph_q, rd_data_a, rd_data_b);
        nxt.gx = ((ph_q == PH_TOP) ? grad_t'(0) : acc.gx) + term.gx;
        nxt.gy = ((ph_q == PH_TOP) ? grad_t'(0) : acc.gy) + term.gy;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q      <= 1'b0;
            ph_q     <= PH_TOP;
            ctr_q    <= '0;
            last_q   <= 1'b0;
            acc      <= '0;
            out_we   <= 1'b0;
            out_addr <= '0;
            out_data <= '0;
            out_last <= 1'b0;
        end else begin
            v_q    <= in_valid;
            ph_q   <= in_phase;
            ctr_q  <= in_ctr;
            last_q <= in_last;
            out_we <= v_q && (ph_q == PH_COL);
            if (v_q) acc <= nxt;
            if (v_q && ph_q == PH_COL) begin
                out_addr <= ctr_q;
                out_data <= magnitude(nxt);
                out_last <= last_q;
            end
        end
    end

endmodule

// File: rtl/sobel_edge_engine.sv
module sobel_edge_engine
    import sobel_pkg::*;
#(
    parameter int IMG_W  = 512,
    parameter int IMG_H  = 512,
    parameter int ADDR_W = $clog2(IMG_W*IMG_H)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr_a,
    output logic [ADDR_W-1:0] rd_addr_b,
    input  logic [7:0]        rd_data_a,
    input  logic [7:0]        rd_data_b,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data
);
    logic              bd_we;
    logic [ADDR_W-1:0] bd_addr;
    phase_e            rd_phase;
    logic [ADDR_W-1:0] rd_ctr;
    logic              rd_last;
    logic              px_we, px_last;
    logic [ADDR_W-1:0] px_addr;
    pix_t              px_data;

    sobel_scan #(.IMG_W(IMG_W), .IMG_H(IMG_H), .ADDR_W(ADDR_W)) u_scan (
        .clk(clk), .rst(rst), .start(start), .done_i(done), .busy(busy),
        .bd_we(bd_we), .bd_addr(bd_addr),
        .rd_en(rd_en), .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .rd_phase(rd_phase), .rd_ctr(rd_ctr), .rd_last(rd_last)
    );

    sobel_accum #(.ADDR_W(ADDR_W)) u_accum (
        .clk(clk), .rst(rst),
        .in_valid(rd_en), .in_phase(rd_phase), .in_ctr(rd_ctr), .in_last(rd_last),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
        .out_we(px_we), .out_addr(px_addr), .out_data(px_data), .out_last(px_last)
    );

    // border pass and interior pass never overlap, so they share one write port
    assign wr_en   = bd_we | px_we;
    assign wr_addr = bd_we ? bd_addr : px_addr;
    assign wr_data = bd_we ? 8'h00 : px_data;

    always_ff @(posedge clk) begin
        if (rst) done <= 1'b0;
        else     done <= px_we & px_last;
    end

endmodule

// File: rtl/sobel_edge_engine_chk.sv
module sobel_edge_engine_chk #(
    parameter int IMG_W  = 512,
    parameter int IMG_H  = 512,
    parameter int ADDR_W = $clog2(IMG_W*IMG_H)
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr_a,
    input logic [ADDR_W-1:0] rd_addr_b,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data
);
    localparam int NPIX = IMG_W*IMG_H;
    logic on_edge;
    always_comb begin
        on_edge = (int'(wr_addr) < IMG_W) || (int'(wr_addr) >= (IMG_H-1)*IMG_W) ||
                  (int'(wr_addr) % IMG_W == 0) || (int'(wr_addr) % IMG_W == IMG_W-1);
    end

    // R2
    border_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en && on_edge |-> wr_data == 8'h00);
    // R6
    write_busy_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy);
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !done |=> busy);
    // R10
    read_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> busy);
    // R10
    read_range_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (int'(rd_addr_a) < NPIX) && (int'(rd_addr_b) < NPIX));
    // R5
    done_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(wr_en));

endmodule

bind sobel_edge_engine sobel_edge_engine_chk #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .rd_en(rd_en), .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/test_sobel_edge_engine.sv
module test_sobel_edge_engine;
    localparam int W  = 9;
    localparam int H  = 6;
    localparam int NP = W*H;
    localparam int AW = $clog2(NP);
    localparam int NI = (W-2)*(H-2);
    localparam int RUN_CYC = 2*W + 2*(H-2) + 4*NI + 3;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic busy, done, rd_en, wr_en;
    logic [AW-1:0] rd_addr_a, rd_addr_b, wr_addr;
    logic [7:0] rd_data_a, rd_data_b, wr_data;

    logic [7:0] img  [NP];
    logic [7:0] outm [NP];
    int wcnt [NP];
    int tests = 0, fails = 0;
    bit mon_on = 0, int_seen = 0;
    int rd_cycles = 0, exp_next = 0;

    always #5 clk = ~clk;

    sobel_edge_engine #(.IMG_W(W), .IMG_H(H)) i_sobel_edge_engine (
        .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
        .rd_en(rd_en), .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // behavioural RAMs
    always @(posedge clk) begin
        if (rd_en) begin
            rd_data_a <= (int'(rd_addr_a) < NP) ? img[rd_addr_a] : 8'hxx;
            rd_data_b <= (int'(rd_addr_b) < NP) ? img[rd_addr_b] : 8'hxx;
        end
        if (wr_en && int'(wr_addr) < NP) outm[wr_addr] <= wr_data;
    end

    function automatic int px(int r, int c);
        return int'(img[r*W + c]);
    endfunction

    function automatic bit is_edge(int a);
        return (a / W == 0) || (a / W == H-1) || (a % W == 0) || (a % W == W-1);
    endfunction

    function automatic int ref_pix(int a);
        int r = a / W, c = a % W, gx, gy, m;
        if (is_edge(a)) return 0;
        gx = (px(r-1,c+1) + 2*px(r,c+1) + px(r+1,c+1)) - (px(r-1,c-1) + 2*px(r,c-1) + px(r+1,c-1));
        gy = (px(r+1,c-1) + 2*px(r+1,c) + px(r+1,c+1)) - (px(r-1,c-1) + 2*px(r-1,c) + px(r-1,c+1));
        m = (gx < 0 ? -gx : gx) + (gy < 0 ? -gy : gy);
        return (m > 255) ? 255 : m;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (mon_on) begin
            if (rd_en) rd_cycles++;
            if (!busy) chk(!wr_en, "R6", "write while idle", int'(wr_en), 0);
            if (wr_en) begin : mon_wr
                int a, e;
                a = int'(wr_addr);
                if (a < NP) wcnt[a]++;
                if (is_edge(a)) begin
                    chk(!int_seen, "R2", "border write after interior", a, -1);
                    chk(wr_data == 8'h00, "R2", "border value", int'(wr_data), 0);
                end else begin
                    int_seen = 1;
                    chk(a == exp_next, "R9", "interior order", a, exp_next);
                    e = ref_pix(a);
                    if (e == 255) chk(int'(wr_data) == e, "R4", "saturated value", int'(wr_data), e);
                    else          chk(int'(wr_data) == e, "R3", "gradient value", int'(wr_data), e);
                    exp_next = (a % W == W-2) ? a + 3 : a + 1;
                end
            end
        end
    end

    task automatic run_frame();
        int k = 0;
        bit got = 0;
        for (int i = 0; i < NP; i++) begin outm[i] = 8'hAA; wcnt[i] = 0; end
        rd_cycles = 0; int_seen = 0; exp_next = W + 1;
        @(negedge clk);
        mon_on = 1;
        start  = 1'b1;
        while (!got && k < 5000) begin
            @(negedge clk);
            k++;
            if (k == 1)  start = 1'b0;
            if (k == 20) start = 1'b1;   // stray start while busy
            if (k == 21) start = 1'b0;
            if (done) got = 1;
        end
        chk(got && k == RUN_CYC, "R5", "cycles to done", k, RUN_CYC);
        @(negedge clk);
        chk(!done, "R7", "done width", int'(done), 0);
        chk(!busy, "R7", "busy after done", int'(busy), 0);
        for (int j = 0; j < 12; j++) begin
            @(negedge clk);
            chk(!busy, "R8", "no frame from stray start", int'(busy), 0);
        end
        mon_on = 0;
        chk(rd_cycles == 4*NI, "R10", "read cycles", rd_cycles, 4*NI);
        for (int i = 0; i < NP; i++) begin
            chk(wcnt[i] == 1, "R6", "writes per address", wcnt[i], 1);
            chk(int'(outm[i]) == ref_pix(i), "R3", "stored pixel", int'(outm[i]), ref_pix(i));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        chk(!busy && !done && !rd_en && !wr_en, "R1", "state in reset",
            int'({busy, done, rd_en, wr_en}), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(!busy && !done && !rd_en && !wr_en, "R1", "state after reset",
            int'({busy, done, rd_en, wr_en}), 0);

        for (int i = 0; i < NP; i++) img[i] = 8'($urandom_range(0, 255));
        run_frame();
        for (int i = 0; i < NP; i++) img[i] = (i % W >= W/2) ? 8'd255 : 8'd0;
        run_frame();
        for (int i = 0; i < NP; i++) img[i] = (i / W >= H/2) ? 8'd200 : 8'd10;
        run_frame();
        for (int i = 0; i < NP; i++) img[i] = 8'((i / W) * 3 + (i % W) * 2);
        run_frame();
        for (int i = 0; i < NP; i++) img[i] = 8'(250 - (i / W) * 7 - (i % W) * 5);
        run_frame();

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule